// File: doc/BRIEF.md
# Multiply, Divide and Multiply-Accumulate Unit

This block is a multi-cycle arithmetic coprocessor that sits beside a 16-bit register file. It reads four 16-bit register pairs (AX, BC, DE, HL) and a 32-bit accumulator through plain operand ports. It runs one of seven operations: an 8x8 unsigned multiply, signed or unsigned 16x16 multiplies, 16-bit and 32-bit unsigned divides, and signed or unsigned multiply-accumulate. Each operation has a fixed latency. Results appear on registered output ports together with a one-cycle `done` strobe. The register file itself lives outside the block.

A caller drives `op` and the operands, then pulses `start` while `busy` is low. Operands are captured on the accepting edge, so the caller may change them afterwards. The divider is a restoring shift-subtract loop that resolves two quotient bits per clock. Dividing by zero gives a defined all-ones quotient and returns the dividend as the remainder. The two multiply-accumulate forms update a carry flag (CY) and an auxiliary flag (AC), each by its own rule.

Operation codes on `op`: 0 = 8x8 unsigned multiply, 1 = 16x16 unsigned multiply, 2 = 16x16 signed multiply, 3 = 16-bit divide, 4 = 32-bit divide, 5 = unsigned MAC, 6 = signed MAC, 7 = reserved.

Top module: `mdu_top`

## Requirements
- R1: After reset, `done` and `busy` are low and every result output (`axOut`, `bcOut`, `deOut`, `hlOut`, `accOut`, `cyOut`, `acOut`) is zero.
- R2: Op 0 multiplies the upper byte of AX by the lower byte of AX. The 16-bit product goes to `axOut`. `done` rises 1 clock after the accepting edge.
- R3: Ops 1 (unsigned) and 2 (signed) multiply AX by BC. The high product half goes to `bcOut` and the low half to `axOut`. `done` rises 2 clocks after the accepting edge.
- R4: Op 3 divides AX by DE, both unsigned. The quotient goes to `axOut` and the remainder to `deOut`. `done` rises 9 clocks after the accepting edge.
- R5: Op 3 with DE equal to zero returns 0xFFFF on `axOut` and the original AX on `deOut`.
- R6: Op 4 divides the 32-bit value {BC,AX} by {HL,DE}, both unsigned. The quotient goes to {`bcOut`,`axOut`} and the remainder to {`hlOut`,`deOut`}. `done` rises 17 clocks after the accepting edge.
- R7: Op 4 with a zero 32-bit divisor returns 0xFFFFFFFF as the quotient and the dividend as the remainder.
- R8: Op 6 adds the signed product AX*BC to the accumulator, modulo 2^32, and drives the sum on `accOut`. `cyOut` is set when bit 31 of the sum differs from bit 31 of the old accumulator. `acOut` equals bit 31 of the sum. `done` rises 3 clocks after the accepting edge.
- R9: Op 5 adds the unsigned product AX*BC to the accumulator, modulo 2^32. `cyOut` is set when the sum is less than the old accumulator. `acOut` is cleared. The latency is 3 clocks.
- R10: Register outputs that an operation does not produce return that operation's captured inputs. Non-MAC ops leave `accOut`, `cyOut` and `acOut` unchanged.
- R11: A `start` pulse while `busy` is high is ignored. The running operation completes with its captured operands, and only one `done` is produced.
- R12: A `start` pulse with op 7 is ignored: `busy` stays low and no `done` follows.
- R13: `done` is high for exactly one cycle per accepted operation. Results hold their values until the next `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch request, sampled when idle |
| op | input | 3 | Operation code |
| axIn | input | 16 | AX operand |
| bcIn | input | 16 | BC operand |
| deIn | input | 16 | DE operand |
| hlIn | input | 16 | HL operand |
| accIn | input | 32 | Accumulator operand |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion strobe |
| axOut | output | 16 | AX result |
| bcOut | output | 16 | BC result |
| deOut | output | 16 | DE result |
| hlOut | output | 16 | HL result |
| accOut | output | 32 | Accumulator result |
| cyOut | output | 1 | Carry flag result |
| acOut | output | 1 | Auxiliary flag result |

## Verification
The assertions assume that `start` is only taken into account when `busy` is low. They also assume the reserved op code never produces a run. Every check ties results to the captured operand copies, so it does not matter whether the caller holds its operand ports steady. The stimulus issues each operation only after `busy` has dropped, with one deliberate exception: a `start` driven with different operands in the middle of a divide, to show that it is rejected. The reserved code is driven only while the unit is idle.

// File: rtl/mdu_pkg.sv
package mdu_pkg;
  localparam int WORD_W = 16;
  localparam int DIV_BITS_PER_CLK = 2;
  localparam int WIDE_W = 2 * WORD_W;
  localparam int LAT_DIVH = WORD_W / DIV_BITS_PER_CLK + 1;
  localparam int LAT_DIVW = WIDE_W / DIV_BITS_PER_CLK + 1;
  localparam int CNT_W = $clog2(LAT_DIVW + 1);

  typedef enum logic [2:0] {
    OP_MUL8U = 3'd0,
    OP_MULHU = 3'd1,
    OP_MULHS = 3'd2,
    OP_DIVH  = 3'd3,
    OP_DIVW  = 3'd4,
    OP_MACU  = 3'd5,
    OP_MACS  = 3'd6,
    OP_RSVD  = 3'd7
  } mduOp_t;

  typedef struct packed {
    logic load;
    logic step;
    logic finish;
  } mduStrobe_t;

  function automatic logic [CNT_W-1:0] opLatency(mduOp_t opSel);
    case (opSel)
      OP_MUL8U:         return CNT_W'(1);
      OP_MULHU, OP_MULHS: return CNT_W'(2);
      OP_MACU, OP_MACS: return CNT_W'(3);
      OP_DIVH:          return CNT_W'(LAT_DIVH);
      OP_DIVW:          return CNT_W'(LAT_DIVW);
      default:          return CNT_W'(1);
    endcase
  endfunction
endpackage

// File: rtl/mdu_ctrl.sv
module mdu_ctrl
  import mdu_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [2:0] op,
  output mduStrobe_t strb,
  output mduOp_t     curOp,
  output logic       busy
);
  logic [CNT_W-1:0] cnt;
  logic accept;

  assign accept      = start && !busy && (mduOp_t'(op) != OP_RSVD);
  assign strb.load   = accept;
  assign strb.step   = busy && (cnt != '0);
  assign strb.finish = busy && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy  <= 1'b0;
      cnt   <= '0;
      curOp <= OP_MUL8U;
    end else if (accept) begin
      busy  <= 1'b1;
      cnt   <= opLatency(mduOp_t'(op)) - CNT_W'(1);
      curOp <= mduOp_t'(op);
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - CNT_W'(1);
    end
  end

  // R11: a run in flight keeps going and keeps its opcode
  a_r11_busy_holds: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cnt != '0) |=> (busy && $stable(curOp)));

  // R12: reserved code never starts a run
  a_r12_rsvd_rejected: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && op == 3'd7) |=> !busy);
endmodule

// File: rtl/mdu_dp.sv
module mdu_dp
  import mdu_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  mduStrobe_t        strb,
  input  logic [2:0]        opIn,
  input  mduOp_t            curOp,
  input  logic [WORD_W-1:0] axIn,
  input  logic [WORD_W-1:0] bcIn,
  input  logic [WORD_W-1:0] deIn,
  input  logic [WORD_W-1:0] hlIn,
  input  logic [WIDE_W-1:0] accIn,
  output logic              done,
  output logic [WORD_W-1:0] axOut,
  output logic [WORD_W-1:0] bcOut,
  output logic [WORD_W-1:0] deOut,
  output logic [WORD_W-1:0] hlOut,
  output logic [WIDE_W-1:0] accOut,
  output logic              cyOut,
  output logic              acOut
);
  localparam int HB = WORD_W / 2;

  logic [WORD_W-1:0] axR, bcR, deR, hlR;
  logic [WIDE_W-1:0] accR, divQuo, divRem, divisor;

  // divider stages, DIV_BITS_PER_CLK per clock
  logic [WIDE_W-1:0] remC [DIV_BITS_PER_CLK+1];
  logic [WIDE_W-1:0] quoC [DIV_BITS_PER_CLK+1];
  assign remC[0] = divRem;
  assign quoC[0] = divQuo;

  for (genvar k = 0; k < DIV_BITS_PER_CLK; k++) begin : g_stage
    logic [WIDE_W:0] shifted;
    logic            fits;
    assign shifted = {remC[k], quoC[k][WIDE_W-1]};
    assign fits    = shifted >= {1'b0, divisor};
    assign remC[k+1] = fits ? WIDE_W'(shifted - {1'b0, divisor}) : shifted[WIDE_W-1:0];
    assign quoC[k+1] = {quoC[k][WIDE_W-2:0], fits};
  end

  // multiplier and accumulate paths
  logic [WORD_W-1:0]        prod8;
  logic [WIDE_W-1:0]        prodU;
  logic signed [WIDE_W-1:0] prodS;
  logic [WIDE_W-1:0]        sumS;
  logic [WIDE_W:0]          sumU;

  always_comb begin
    prod8 = WORD_W'(axR[WORD_W-1:HB]) * WORD_W'(axR[HB-1:0]);
    prodU = WIDE_W'(axR) * WIDE_W'(bcR);
    prodS = $signed(axR) * $signed(bcR);
    sumS  = accR + WIDE_W'(prodS);
    sumU  = {1'b0, accR} + {1'b0, prodU};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      axR <= '0; bcR <= '0; deR <= '0; hlR <= '0; accR <= '0;
      divQuo <= '0; divRem <= '0; divisor <= '0;
      done <= 1'b0;
      axOut <= '0; bcOut <= '0; deOut <= '0; hlOut <= '0;
      accOut <= '0; cyOut <= 1'b0; acOut <= 1'b0;
    end else begin
      done <= strb.finish;
      if (strb.load) begin
        axR <= axIn; bcR <= bcIn; deR <= deIn; hlR <= hlIn; accR <= accIn;
        divRem <= '0;
        if (mduOp_t'(opIn) == OP_DIVH) begin
          divQuo  <= {axIn, {WORD_W{1'b0}}};
          divisor <= {{WORD_W{1'b0}}, deIn};
        end else begin
          divQuo  <= {bcIn, axIn};
          divisor <= {hlIn, deIn};
        end
      end
      if (strb.step && (curOp == OP_DIVH || curOp == OP_DIVW)) begin
        divRem <= remC[DIV_BITS_PER_CLK];
        divQuo <= quoC[DIV_BITS_PER_CLK];
      end
      if (strb.finish) begin
        axOut <= axR; bcOut <= bcR; deOut <= deR; hlOut <= hlR;
        case (curOp)
          OP_MUL8U: axOut <= prod8;
          OP_MULHU: {bcOut, axOut} <= prodU;
          OP_MULHS: {bcOut, axOut} <= WIDE_W'(prodS);
          OP_DIVH: begin
            axOut <= divQuo[WORD_W-1:0];
            deOut <= divRem[WORD_W-1:0];
          end
          OP_DIVW: begin
            {bcOut, axOut} <= divQuo;
            {hlOut, deOut} <= divRem;
          end
          OP_MACU: begin
            accOut <= sumU[WIDE_W-1:0];
            cyOut  <= sumU[WIDE_W];
            acOut  <= 1'b0;
          end
          OP_MACS: begin
            accOut <= sumS;
            cyOut  <= sumS[WIDE_W-1] ^ accR[WIDE_W-1];
            acOut  <= sumS[WIDE_W-1];
          end
          default: ;
        endcase
      end
    end
  end

  // R5: zero 16-bit divisor gives all-ones quotient and dividend remainder
  a_r5_divh_zero: assert property (@(posedge clk) disable iff (!rstN)
    (strb.finish && curOp == OP_DIVH && deR == '0) |=> (axOut == '1 && deOut == axR));

  // R7: zero 32-bit divisor
  a_r7_divw_zero: assert property (@(posedge clk) disable iff (!rstN)
    (strb.finish && curOp == OP_DIVW && {hlR, deR} == '0)
      |=> ({bcOut, axOut} == '1 && {hlOut, deOut} == {bcR, axR}));

  // R9: unsigned accumulate clears AC
  a_r9_macu_ac_clear: assert property (@(posedge clk) disable iff (!rstN)
    (strb.finish && curOp == OP_MACU) |=> !acOut);

  // R10: non-MAC ops leave accumulator and flags alone
  a_r10_acc_kept: assert property (@(posedge clk) disable iff (!rstN)
    (strb.finish && curOp != OP_MACU && curOp != OP_MACS)
      |=> ($stable(accOut) && $stable(cyOut) && $stable(acOut)));

  // R13: done is a single-cycle pulse
  a_r13_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
endmodule

// File: rtl/mdu_top.sv
module mdu_top
  import mdu_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [2:0]  op,
  input  logic [15:0] axIn,
  input  logic [15:0] bcIn,
  input  logic [15:0] deIn,
  input  logic [15:0] hlIn,
  input  logic [31:0] accIn,
  output logic        busy,
  output logic        done,
  output logic [15:0] axOut,
  output logic [15:0] bcOut,
  output logic [15:0] deOut,
  output logic [15:0] hlOut,
  output logic [31:0] accOut,
  output logic        cyOut,
  output logic        acOut
);
  mduStrobe_t strb;
  mduOp_t     curOp;

  mdu_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .op(op),
    .strb(strb), .curOp(curOp), .busy(busy)
  );

  mdu_dp dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .opIn(op), .curOp(curOp),
    .axIn(axIn), .bcIn(bcIn), .deIn(deIn), .hlIn(hlIn), .accIn(accIn),
    .done(done), .axOut(axOut), .bcOut(bcOut), .deOut(deOut), .hlOut(hlOut),
    .accOut(accOut), .cyOut(cyOut), .acOut(acOut)
  );
endmodule

// File: tb/mdu_top_tb_top.sv
module mdu_top_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [2:0] op = '0;
  logic [15:0] axIn = '0, bcIn = '0, deIn = '0, hlIn = '0;
  logic [31:0] accIn = '0;
  logic busy, done, cyOut, acOut;
  logic [15:0] axOut, bcOut, deOut, hlOut;
  logic [31:0] accOut;

  always #2 clk = ~clk;

  mdu_top dut_i (.*);

  typedef struct {
    int          lat;
    int          startCyc;
    logic [15:0] ax, bc, de, hl;
    logic [31:0] acc;
    logic        cy, ac;
    string       tag;
  } expItem_t;

  expItem_t sb[$];
  int errors = 0;
  int checks = 0;
  int cyc = 0;
  logic [31:0] mAcc = '0;
  logic mCy = 1'b0, mAc = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // driver: waits for idle, computes expected result, pushes it, pulses start
  task automatic issue(input logic [2:0] o, input logic [15:0] a, input logic [15:0] b,
                       input logic [15:0] d, input logic [15:0] h, input logic [31:0] c,
                       input string tag);
    expItem_t e;
    logic [31:0] pu, q, r, n, dv;
    logic signed [31:0] ps;
    logic [32:0] su;
    @(negedge clk);
    while (busy) @(negedge clk);
    e.ax = a; e.bc = b; e.de = d; e.hl = h;
    e.acc = mAcc; e.cy = mCy; e.ac = mAc; e.tag = tag;
    pu = 32'(a) * 32'(b);
    ps = $signed(a) * $signed(b);
    case (o)
      3'd0: begin e.ax = 16'(a[15:8]) * 16'(a[7:0]); e.lat = 1; end
      3'd1: begin {e.bc, e.ax} = pu; e.lat = 2; end
      3'd2: begin {e.bc, e.ax} = ps; e.lat = 2; end
      3'd3: begin
        e.lat = 9;
        if (d == 0) begin e.ax = 16'hFFFF; e.de = a; end
        else begin e.ax = a / d; e.de = a % d; end
      end
      3'd4: begin
        e.lat = 17; n = {b, a}; dv = {h, d};
        if (dv == 0) begin q = 32'hFFFF_FFFF; r = n; end
        else begin q = n / dv; r = n % dv; end
        {e.bc, e.ax} = q; {e.hl, e.de} = r;
      end
      3'd5: begin
        e.lat = 3; su = {1'b0, c} + {1'b0, pu};
        e.acc = su[31:0]; e.cy = (su[31:0] < c); e.ac = 1'b0;
      end
      default: begin
        e.lat = 3; e.acc = c + 32'(ps);
        e.cy = e.acc[31] ^ c[31]; e.ac = e.acc[31];
      end
    endcase
    mAcc = e.acc; mCy = e.cy; mAc = e.ac;
    op = o; axIn = a; bcIn = b; deIn = d; hlIn = h; accIn = c; start = 1'b1;
    e.startCyc = cyc;
    sb.push_back(e);
    @(negedge clk);
    start = 1'b0;
    axIn = ~a; bcIn = ~b; deIn = ~d; hlIn = ~h; accIn = ~c;
  endtask

  // monitor: pops and compares on each done, checks hold after done (R13)
  logic prevDone = 1'b0;
  logic [15:0] hAx;
  logic [31:0] hAcc;
  always @(negedge clk) begin
    if (rstN) begin
      if (prevDone) begin
        chk(!done, "R13 done pulse width", 64'(done), 64'd0);
        chk(axOut == hAx && accOut == hAcc, "R13 results hold", 64'(axOut), 64'(hAx));
      end
      if (done) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R11/R12 unexpected done", 64'd1, 64'd0);
        end else begin
          expItem_t e;
          e = sb.pop_front();
          chk(cyc - e.startCyc - 1 == e.lat, {e.tag, " latency"}, 64'(cyc - e.startCyc - 1), 64'(e.lat));
          chk(axOut == e.ax, {e.tag, " axOut"}, 64'(axOut), 64'(e.ax));
          chk(bcOut == e.bc, {e.tag, " bcOut"}, 64'(bcOut), 64'(e.bc));
          chk(deOut == e.de, {e.tag, " deOut"}, 64'(deOut), 64'(e.de));
          chk(hlOut == e.hl, {e.tag, " hlOut"}, 64'(hlOut), 64'(e.hl));
          chk(accOut == e.acc, {e.tag, " accOut"}, 64'(accOut), 64'(e.acc));
          chk(cyOut == e.cy, {e.tag, " cyOut"}, 64'(cyOut), 64'(e.cy));
          chk(acOut == e.ac, {e.tag, " acOut"}, 64'(acOut), 64'(e.ac));
        end
        hAx = axOut; hAcc = accOut;
      end
      prevDone = done;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!done && !busy, "R1 done/busy after reset", 64'({done, busy}), 64'd0);
    chk(axOut == 0 && bcOut == 0 && deOut == 0 && hlOut == 0, "R1 regs after reset",
        64'({axOut, bcOut, deOut, hlOut}), 64'd0);
    chk(accOut == 0 && !cyOut && !acOut, "R1 acc/flags after reset", 64'({accOut, cyOut, acOut}), 64'd0);

    issue(3'd0, 16'hFFFF, 16'h1111, 16'h2222, 16'h3333, 32'h0, "R2 mul8 max R10");
    issue(3'd0, 16'h1234, 16'hAAAA, 16'hBBBB, 16'hCCCC, 32'h5, "R2 mul8");
    issue(3'd1, 16'hFFFF, 16'hFFFF, 16'h0101, 16'h0202, 32'h0, "R3 mulhu max");
    issue(3'd2, 16'h8000, 16'h8000, 16'h0, 16'h0, 32'h0, "R3 mulhs min*min");
    issue(3'd2, 16'hFFFF, 16'h0002, 16'h0, 16'h0, 32'h0, "R3 mulhs neg");
    issue(3'd3, 16'd1000, 16'h7777, 16'd7, 16'h9999, 32'h0, "R4 div16");
    issue(3'd3, 16'hFFFF, 16'h0, 16'd1, 16'h0, 32'h0, "R4 div16 by one");
    issue(3'd3, 16'd5, 16'h0, 16'd9, 16'h0, 32'h0, "R4 div16 small");
    issue(3'd3, 16'hBEEF, 16'h1234, 16'd0, 16'h5678, 32'h0, "R5 div16 zero");
    issue(3'd4, 16'h5678, 16'h1234, 16'h00FF, 16'h0000, 32'h0, "R6 div32");
    issue(3'd4, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 32'h0, "R6 div32 equal");
    issue(3'd4, 16'hCAFE, 16'hDEAD, 16'h0, 16'h0, 32'h0, "R7 div32 zero");
    issue(3'd6, 16'h7FFF, 16'h7FFF, 16'h0, 16'h0, 32'h7FFF_0000, "R8 macs sign flip");
    issue(3'd6, 16'hFFFF, 16'h0003, 16'h0, 16'h0, 32'h0000_0010, "R8 macs no flip");
    issue(3'd5, 16'hFFFF, 16'hFFFF, 16'h0, 16'h0, 32'hFFFF_0000, "R9 macu wrap");
    issue(3'd5, 16'h0002, 16'h0003, 16'h0, 16'h0, 32'h8000_0000, "R9 macu no wrap");
    issue(3'd1, 16'h0003, 16'h0004, 16'h0, 16'h0, 32'h0, "R10 acc kept after mac");

    // R11: start during a running divide is ignored
    issue(3'd4, 16'h0000, 16'h0100, 16'h0010, 16'h0000, 32'h0, "R11 running div32");
    op = 3'd0; axIn = 16'h0505; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy, "R11 still busy", 64'(busy), 64'd1);

    // R12: reserved opcode never starts
    @(negedge clk);
    while (busy) @(negedge clk);
    @(negedge clk);
    op = 3'd7; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 6; i++) begin
      chk(!busy, "R12 reserved op stays idle", 64'(busy), 64'd0);
      @(negedge clk);
    end

    for (int i = 0; i < 40; i++) begin
      logic [2:0] o;
      o = 3'($urandom_range(0, 6));
      issue(o, 16'($urandom), 16'($urandom), 16'($urandom_range(0, 3) == 0 ? 0 : $urandom),
            16'($urandom_range(0, 1) == 0 ? 0 : $urandom), 32'($urandom), "R2-mix random");
    end

    @(negedge clk);
    while (busy || sb.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(sb.size() == 0, "R13 all results returned", 64'(sb.size()), 64'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule